// File: doc/BRIEF.md
# Bit-Serial Vector Adder with Running Sum

This block adds vectors of 16 elements, each 16 bits wide, one bit per clock. Each element has its own lane: a single-bit full adder with a carry register. The lanes start in a staggered order, one clock apart. Operand bits come least significant bit first from two parallel operand banks, X and Y, and a multiplexer picks the current bit. Each lane shifts its sum bits into a word. When the word is complete it is written into a result bank, which is read through a combinational read port.

There are two modes. In element-wise mode, lane i computes Z(i) = X(i) + Y(i). In accumulate mode, the Y operand is not used. Each lane instead takes its second input from the registered sum bit of the lane before it, and lane 0 takes zero. Because of the one-clock stagger, that bit is exactly the bit of the same weight. The result bank therefore ends up holding running sums, and its last entry is the sum of the whole vector.

A controller with three states sequences the work:
- IDLE goes to RUN when a start strobe arrives.
- RUN goes to FIN when the step counter reaches its final step.
- FIN always returns to IDLE.

The done output is high only in FIN.

Top module: `vec_serial_adder`

## Requirements
- R1: Each lane's single-bit cell produces sum = x XOR y XOR cin and carry = majority(x, y, cin). Results are therefore ordinary binary sums.
- R2: Bits are processed least significant first. The carry is held in a register for one clock between bit positions and is forced to zero on each element's first bit, so no carry from an earlier operation leaks in.
- R3: In element-wise mode (mode = 0), entry i of the result bank becomes (X(i) + Y(i)) mod 2^16 for every i in 0..15.
- R4: In accumulate mode (mode = 1), entry i becomes (X(0) + ... + X(i)) mod 2^16. The running sum starts from zero, and the contents of Y have no effect.
- R5: The start edge counts as edge 0. Entry 0 is written at edge 16, and entry i at edge 16 + i. Only one entry is written per clock.
- R6: When a start is accepted, the whole result bank is cleared to zero.
- R7: done is high for exactly one clock, visible after edge 31 counted from the start edge, and then falls.
- R8: A start strobe that arrives while an operation runs or while done is high is ignored. The mode is captured when start is accepted.
- R9: A load (ld_sel = 0 writes X, ld_sel = 1 writes Y, at entry ld_idx) takes effect when idle and is ignored while busy.
- R10: After reset, done is low and every operand and result entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| mode | input | 1 | 0 element-wise, 1 accumulate |
| ld_en | input | 1 | Operand load strobe |
| ld_sel | input | 1 | 0 selects bank X, 1 selects bank Y |
| ld_idx | input | 4 | Operand entry index |
| ld_data | input | 16 | Operand word |
| rd_idx | input | 4 | Result entry index |
| rd_data | output | 16 | Result entry contents |
| done | output | 1 | One-clock completion pulse |

## Verification
Two of the block's functions can land in the same clock: a new start or load request, and an operation that is still in progress or is just raising done. The bench provokes this in two ways. It pulses start with the opposite mode and loads a different X(0) midway through a run. It also pulses start again in the very clock where done is high. It then checks that only one done pulse appears, that the results still match the original operands in the original mode, and that a following run shows X(0) was never overwritten.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } vsa_state_e;

    typedef enum logic {
        MODE_ELEM = 1'b0,
        MODE_ACC  = 1'b1
    } vsa_mode_e;
endpackage

// File: rtl/vsa_fa.sv
module vsa_fa (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    assign s  = a ^ b ^ ci;
    assign co = (a & b) | (a & ci) | (b & ci);
endmodule

// File: rtl/vsa_lane.sv
module vsa_lane #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             first,
    input  logic             x_bit,
    input  logic             y_bit,
    output logic             sum_q,
    output logic [WIDTH-1:0] word
);
    logic             carry_q;
    logic             cin;
    logic             s;
    logic             co;
    logic [WIDTH-2:0] sh_q;

    // carry restarts at zero on each element's lowest bit (R2)
    assign cin = first ? 1'b0 : carry_q;

    vsa_fa u_fa (
        .a (x_bit),
        .b (y_bit),
        .ci(cin),
        .s (s),
        .co(co)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            sh_q    <= '0;
            sum_q   <= 1'b0;
        end else begin
            sum_q <= active ? s : 1'b0;
            if (active) begin
                carry_q <= co;
                sh_q    <= {s, sh_q[WIDTH-2:1]};
            end
        end
    end

    // on the last bit the live sum bit becomes the MSB
    assign word = {s, sh_q};
endmodule

// File: rtl/vsa_ctrl.sv
module vsa_ctrl
    import vsa_pkg::*;
#(
    parameter int STEPS = 31,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          run,
    output logic          busy,
    output logic          done,
    output logic          accept,
    output logic [CW-1:0] step
);
    vsa_state_e state_q, state_d;
    logic       last;

    assign last = (step == CW'(STEPS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (last)  state_d = ST_FIN;
            ST_FIN:             state_d = ST_IDLE;
            default:            state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              step <= '0;
        else if (accept)         step <= '0;
        else if (run && !last)   step <= step + 1'b1;
    end

    always_comb begin
        run    = (state_q == ST_RUN);
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_FIN);
        accept = (state_q == ST_IDLE) && start;
    end

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !last && start) |=> (state_q == ST_RUN));

    p_fin_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/vec_serial_adder.sv
module vec_serial_adder
    import vsa_pkg::*;
#(
    parameter int ELEMS = 16,
    parameter int WIDTH = 16,
    localparam int IW    = (ELEMS > 1) ? $clog2(ELEMS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    input  logic             ld_en,
    input  logic             ld_sel,
    input  logic [IW-1:0]    ld_idx,
    input  logic [WIDTH-1:0] ld_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data,
    output logic             done
);
    localparam int BW    = $clog2(WIDTH);
    localparam int STEPS = ELEMS + WIDTH - 1;
    // 2^CW >= ELEMS+WIDTH, so step-lane wraps above WIDTH before a lane starts
    localparam int CW    = $clog2(STEPS + 1);

    logic [ELEMS-1:0][WIDTH-1:0] op_x, op_y, z_q;
    logic [ELEMS-1:0][WIDTH-1:0] words;
    logic [ELEMS-1:0]            wr_vec;
    logic [ELEMS-1:0]            fb_vec;
    logic                        run, busy, accept;
    logic [CW-1:0]               step;
    vsa_mode_e                   mode_q;

    vsa_ctrl #(.STEPS(STEPS), .CW(CW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .run   (run),
        .busy  (busy),
        .done  (done),
        .accept(accept),
        .step  (step)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mode_q <= MODE_ELEM;
        else if (accept) mode_q <= vsa_mode_e'(mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_x <= '0;
            op_y <= '0;
        end else if (ld_en && !busy) begin
            if (ld_sel) op_y[ld_idx] <= ld_data;
            else        op_x[ld_idx] <= ld_data;
        end
    end

    for (genvar g = 0; g < ELEMS; g++) begin : g_lane
        logic [CW-1:0] rel;
        logic          act, y_src;

        assign rel = step - CW'(g);
        assign act = run && (rel < CW'(WIDTH));

        if (g == 0) begin : g_head
            assign y_src = (mode_q == MODE_ACC) ? 1'b0 : op_y[g][rel[BW-1:0]];
        end else begin : g_tail
            assign y_src = (mode_q == MODE_ACC) ? fb_vec[g-1] : op_y[g][rel[BW-1:0]];
        end

        assign wr_vec[g] = act && (rel == CW'(WIDTH - 1));

        vsa_lane #(.WIDTH(WIDTH)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .active(act),
            .first (rel == '0),
            .x_bit (op_x[g][rel[BW-1:0]]),
            .y_bit (y_src),
            .sum_q (fb_vec[g]),
            .word  (words[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            z_q <= '0;
        end else if (accept) begin
            z_q <= '0;
        end else begin
            for (int i = 0; i < ELEMS; i++)
                if (wr_vec[i]) z_q[i] <= words[i];
        end
    end

    assign rd_data = z_q[rd_idx];

    p_load_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ld_en) |=> ($stable(op_x) && $stable(op_y)));

    p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));

    p_write_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_vec) |-> run);

    p_fb_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fb_vec == '0));
endmodule

// File: tb/tb_vec_serial_adder.sv
module tb_vec_serial_adder;
    localparam int E = 16;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic          ld_en = 1'b0;
    logic          ld_sel = 1'b0;
    logic [3:0]    ld_idx = '0;
    logic [W-1:0]  ld_data = '0;
    logic [3:0]    rd_idx = '0;
    logic [W-1:0]  rd_data;
    logic          done;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    logic [W-1:0] mx [E];
    logic [W-1:0] my [E];

    always #10 clk = ~clk;

    vec_serial_adder dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_idx(ld_idx), .ld_data(ld_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .done(done)
    );

    always @(negedge clk) if (done === 1'b1) done_cnt++;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic read_z(input int idx, output logic [W-1:0] v);
        rd_idx = 4'(idx);
        #1;
        v = rd_data;
    endtask

    task automatic load(input logic sel, input int idx, input logic [W-1:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_idx = 4'(idx); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic load_all();
        for (int i = 0; i < E; i++) begin
            load(1'b0, i, mx[i]);
            load(1'b1, i, my[i]);
        end
    endtask

    task automatic run_op(input logic md, output int lat, output int width);
        @(negedge clk);
        mode = md; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (done !== 1'b1 && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        width = 0;
        while (done === 1'b1 && width < 10) begin
            width++;
            @(negedge clk);
        end
    endtask

    task automatic check_elem(input string tag);
        logic [W-1:0] v;
        for (int i = 0; i < E; i++) begin
            read_z(i, v);
            chk("R3", $sformatf("%s Z[%0d]", tag, i), v, (mx[i] + my[i]) & 16'hFFFF);
        end
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        chk("R10", "done after reset", done, 0);
        for (int i = 0; i < E; i++) begin
            read_z(i, v);
            chk("R10", $sformatf("Z[%0d] after reset", i), v, 0);
        end
    endtask

    task automatic t_elementwise();
        int lat, wid;
        for (int i = 0; i < E; i++) begin
            mx[i] = W'(i * 4097 + 3);
            my[i] = W'(16'hF00F - i * 13);
        end
        load_all();
        run_op(1'b0, lat, wid);
        check_elem("patA");
        chk("R7", "latency", lat, 31);
        chk("R7", "done width", wid, 1);
        for (int i = 0; i < E; i++) begin
            mx[i] = (i % 2) ? 16'hAAAA : 16'h5555;
            my[i] = (i % 3) ? 16'h5555 : 16'h8001;
        end
        load_all();
        run_op(1'b0, lat, wid);
        check_elem("patB R1");
    endtask

    task automatic t_carry_clear();
        int lat, wid;
        logic [W-1:0] v;
        for (int i = 0; i < E; i++) begin mx[i] = 16'hFFFF; my[i] = 16'h0001; end
        load_all();
        run_op(1'b0, lat, wid);
        read_z(7, v);
        chk("R3", "wrap FFFF+1", v, 0);
        for (int i = 0; i < E; i++) begin mx[i] = 16'h0000; my[i] = 16'h0000; end
        load_all();
        run_op(1'b0, lat, wid);
        for (int i = 0; i < E; i++) begin
            read_z(i, v);
            chk("R2", $sformatf("no carry leak Z[%0d]", i), v, 0);
        end
    endtask

    task automatic t_accumulate();
        int lat, wid;
        logic [W-1:0] v, acc;
        for (int i = 0; i < E; i++) begin
            mx[i] = W'(16'h1111 * (i + 1) + i);
            my[i] = W'(16'hBEEF ^ i);
        end
        load_all();
        run_op(1'b1, lat, wid);
        acc = '0;
        for (int i = 0; i < E; i++) begin
            acc = acc + mx[i];
            read_z(i, v);
            chk("R4", $sformatf("prefix Z[%0d]", i), v, acc);
        end
        chk("R7", "acc latency", lat, 31);
    endtask

    task automatic t_timing();
        logic [W-1:0] v;
        for (int i = 0; i < E; i++) begin mx[i] = W'(i + 100); my[i] = W'(i + 7); end
        load_all();
        @(negedge clk);
        mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        read_z(0, v); chk("R6", "Z[0] cleared on start", v, 0);
        for (int c = 1; c <= 31; c++) begin
            @(negedge clk);
            if (c == 15) begin read_z(0, v); chk("R5", "Z[0] edge15", v, 0); end
            if (c == 16) begin
                read_z(0, v); chk("R5", "Z[0] edge16", v, 107);
                read_z(1, v); chk("R5", "Z[1] edge16", v, 0);
            end
            if (c == 17) begin read_z(1, v); chk("R5", "Z[1] edge17", v, 109); end
            if (c == 30) begin
                read_z(15, v); chk("R5", "Z[15] edge30", v, 0);
                chk("R7", "done edge30", done, 0);
            end
            if (c == 31) begin
                read_z(15, v); chk("R5", "Z[15] edge31", v, 137);
                chk("R7", "done edge31", done, 1);
            end
        end
        @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        int base, lat, wid, n;
        logic [W-1:0] v;
        for (int i = 0; i < E; i++) begin mx[i] = W'(16'h0F0F + i * 257); my[i] = W'(i * 3 + 1); end
        load_all();
        base = done_cnt;
        @(negedge clk);
        mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        start = 1'b1; mode = 1'b1;
        ld_en = 1'b1; ld_sel = 1'b0; ld_idx = 4'd0; ld_data = 16'hAAAA;
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0;
        n = 0;
        while (done !== 1'b1 && n < 200) begin @(negedge clk); n++; end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        chk("R8", "done pulses", done_cnt - base, 1);
        check_elem("busy R8");
        run_op(1'b0, lat, wid);
        read_z(0, v);
        chk("R9", "X[0] kept", v, (mx[0] + my[0]) & 16'hFFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_elementwise();
        t_carry_clear();
        t_accumulate();
        t_timing();
        t_busy_ignore();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule